// File: doc/BRIEF.md
# Transparent-Module Test Session Controller

This block steers test access in a system built from several modules, each of which has a functional mode and a transparent mode that passes its inputs straight to its outputs. A compact session code picks which module is under test. The controller decodes that code and drives one transparency control line per module. The module under test is left functional and every other module is made transparent, so patterns reach it from the system inputs and its responses reach the system outputs in a single cycle.

A reserved code makes every module transparent at once, which exposes the wiring between modules for interconnect testing. Codes beyond the last defined session fall back to that all-transparent state, so a bad code can never leave two modules functional together. When test is disabled, every module runs functionally.

The system contains one feedback loop, broken at its narrowest bus. While any test session is active, the controller flips the select of the multiplexer on that bus, so that the bus is fed from a primary input instead of the loop-back path. Both the transparency vector and the loop-break select come from registers, so they change only on a clock edge and never glitch while the code is decoded.

Top module: `sess_ctrl`

## Requirements
- R1: While the active-low reset is asserted, every transparency control line is 0 (functional) and the loop-break select is 0 (loop-back path). This takes effect at once, without waiting for a clock edge.
- R2: When test enable was low at the previous rising edge, every transparency control line is 0 and the loop-break select is 0, whatever the session code is.
- R3: When test enable is high with session code k, where k is below the module count (0 to 4 by default), line k is 0 and every other line is 1 (one-cold).
- R4: When test enable is high with session code equal to the module count (5 by default), every transparency control line is 1.
- R5: When test enable is high with a session code above the module count (6 and 7 by default), every transparency control line is 1.
- R6: The loop-break select is 1 (primary input feeds the narrow feedback bus) exactly when test enable was high at the previous rising edge, for every session code.
- R7: The outputs reflect the inputs sampled at the most recent rising edge. A change of inputs between edges leaves the outputs unchanged until the next rising edge.
- R8: While the loop-break select is 1, at most one transparency control line is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | 1 = test session active, 0 = normal system operation |
| sess_code_i | input | 3 | Encoded session code: module index, all-transparent code, or unused code |
| xp_ctl_o | output | 5 | Per-module transparency control, 1 = transparent, 0 = functional |
| lb_pin_sel_o | output | 1 | Loop-break multiplexer select, 1 = primary input, 0 = loop-back path |

## Verification
The hardest state to reach from the ports is a code change that falls between clock edges. On a correct design it must leave the mode lines untouched until the next rising edge. The stimulus changes both inputs just after a falling edge, probes the outputs a quarter period later, and then probes again after the edge. A long run of random pairs of enable and code, with the unused codes included, then moves the controller straight between one-cold, all-transparent and all-functional states. The same run checks the one-cold vector against each module index. It also asserts reset in the middle of an active session to show that the outputs drop at once.

// File: rtl/sess_ctrl_pkg.sv
package sess_ctrl_pkg;

    // Source that feeds the narrow feedback bus
    typedef enum logic {
        FB_FROM_LOOP = 1'b0,
        FB_FROM_PIN  = 1'b1
    } fb_src_e;

endpackage

// File: rtl/sess_ctrl_dec.sv
module sess_ctrl_dec #(
    parameter int NUM_MODS = 5,
    parameter int SEL_W    = $clog2(NUM_MODS + 1)
) (
    input  logic                test_en,
    input  logic [SEL_W-1:0]    code,
    output logic [NUM_MODS-1:0] xp_ctl
);

    localparam logic [SEL_W-1:0] ALLX_CODE = SEL_W'(NUM_MODS);

    logic all_xp;

    // The reserved code and every code above it make all modules transparent
    assign all_xp = (code >= ALLX_CODE);

    for (genvar g = 0; g < NUM_MODS; g++) begin : g_line
        assign xp_ctl[g] = test_en && (all_xp || (code != SEL_W'(g)));
    end

endmodule

// File: rtl/sess_ctrl_loopbrk.sv
module sess_ctrl_loopbrk
    import sess_ctrl_pkg::*;
(
    input  logic    test_en,
    output fb_src_e fb_src
);

    // Any active session cuts the loop and drives the bus from a pin
    always_comb begin
        fb_src = FB_FROM_LOOP;
        if (test_en) begin
            fb_src = FB_FROM_PIN;
        end
    end

endmodule

// File: rtl/sess_ctrl.sv
module sess_ctrl
    import sess_ctrl_pkg::*;
#(
    parameter int NUM_MODS = 5,
    parameter int SEL_W    = $clog2(NUM_MODS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                test_en_i,
    input  logic [SEL_W-1:0]    sess_code_i,
    output logic [NUM_MODS-1:0] xp_ctl_o,
    output logic                lb_pin_sel_o
);

    typedef struct packed {
        logic [NUM_MODS-1:0] xp;
        fb_src_e             fb;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{xp: '0, fb: FB_FROM_LOOP};

    logic [NUM_MODS-1:0] dec_xp;
    fb_src_e             brk_src;
    ctl_t                ctl_d;
    ctl_t                ctl_q;

    sess_ctrl_dec #(
        .NUM_MODS (NUM_MODS),
        .SEL_W    (SEL_W)
    ) u_dec (
        .test_en (test_en_i),
        .code    (sess_code_i),
        .xp_ctl  (dec_xp)
    );

    sess_ctrl_loopbrk u_brk (
        .test_en (test_en_i),
        .fb_src  (brk_src)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.xp = dec_xp;
        ctl_d.fb = brk_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign xp_ctl_o     = ctl_q.xp;
    assign lb_pin_sel_o = (ctl_q.fb == FB_FROM_PIN);

endmodule

// File: rtl/sess_ctrl_chk.sv
module sess_ctrl_chk #(
    parameter int NUM_MODS = 5,
    parameter int SEL_W    = $clog2(NUM_MODS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                test_en_i,
    input logic [SEL_W-1:0]    sess_code_i,
    input logic [NUM_MODS-1:0] xp_ctl_o,
    input logic                lb_pin_sel_o
);

    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_MODS);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (xp_ctl_o == '0 && !lb_pin_sel_o); // R1
        end
    end

    AST_LB_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lb_pin_sel_o == $past(test_en_i))); // R6

    AST_OFF_ALL_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        !lb_pin_sel_o |-> (xp_ctl_o == '0)); // R2

    AST_AT_MOST_ONE_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        lb_pin_sel_o |-> ($countones(~xp_ctl_o) <= 1)); // R8

    AST_TARGET_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_en_i) && ($past(sess_code_i) < LAST_CODE))
        |-> !xp_ctl_o[$past(sess_code_i)]); // R3

    AST_SPARE_ALL_XP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_en_i) && ($past(sess_code_i) >= LAST_CODE))
        |-> (&xp_ctl_o)); // R4 R5

endmodule

bind sess_ctrl sess_ctrl_chk #(
    .NUM_MODS (NUM_MODS),
    .SEL_W    (SEL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .test_en_i    (test_en_i),
    .sess_code_i  (sess_code_i),
    .xp_ctl_o     (xp_ctl_o),
    .lb_pin_sel_o (lb_pin_sel_o)
);

// File: tb/test_sess_ctrl.sv
module test_sess_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_MODS   = 5;
    localparam int SEL_W      = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                test_en = 1'b0;
    logic [SEL_W-1:0]    code = '0;
    logic [NUM_MODS-1:0] xp;
    logic                lb;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sess_ctrl #(.NUM_MODS(NUM_MODS), .SEL_W(SEL_W)) i_sess_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_en_i    (test_en),
        .sess_code_i  (code),
        .xp_ctl_o     (xp),
        .lb_pin_sel_o (lb)
    );

    function automatic logic [NUM_MODS-1:0] exp_xp(input logic en, input logic [SEL_W-1:0] c);
        logic [NUM_MODS-1:0] v;
        if (!en) return '0;
        v = '1;
        if (int'(c) < NUM_MODS) v[c] = 1'b0;
        return v;
    endfunction

    task automatic check(input string req, input logic [NUM_MODS:0] got, input logic [NUM_MODS:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got xp/lb=%b expected %b", req, got, want);
        end
    endtask

    // Drive after a falling edge, check after the following falling edge
    task automatic apply(input string req, input logic en, input logic [SEL_W-1:0] c);
        @(negedge clk);
        test_en = en;
        code    = c;
        @(negedge clk);
        check(req, {xp, lb}, {exp_xp(en, c), en});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic en_r;
        logic [SEL_W-1:0] c_r;
        void'($urandom(32'd4242));

        // R1: reset state
        #(CLK_PERIOD * 2 + 1);
        check("R1", {xp, lb}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: test disabled, every code ignored
        for (int k = 0; k < (1 << SEL_W); k++) apply("R2", 1'b0, SEL_W'(k));

        // R3 and R6: each module under test in turn
        for (int k = 0; k < NUM_MODS; k++) apply("R3", 1'b1, SEL_W'(k));

        // R4: interconnect session
        apply("R4", 1'b1, SEL_W'(NUM_MODS));

        // R5: unused codes
        for (int k = NUM_MODS + 1; k < (1 << SEL_W); k++) apply("R5", 1'b1, SEL_W'(k));

        // R7: mid-cycle change is held until the next rising edge
        apply("R7", 1'b1, 3'd2);
        @(negedge clk);
        test_en = 1'b1;
        code    = 3'd0;
        #(CLK_PERIOD / 4);
        check("R7", {xp, lb}, {exp_xp(1'b1, 3'd2), 1'b1});
        @(negedge clk);
        check("R7", {xp, lb}, {exp_xp(1'b1, 3'd0), 1'b1});
        @(negedge clk);
        test_en = 1'b0;
        #(CLK_PERIOD / 4);
        check("R7", {xp, lb}, {exp_xp(1'b1, 3'd0), 1'b1});
        @(negedge clk);
        check("R2", {xp, lb}, '0);

        // Random mix of sessions, R6 and R8 on each
        for (int i = 0; i < 300; i++) begin
            en_r = 1'($urandom);
            c_r  = SEL_W'($urandom);
            apply("R6", en_r, c_r);
            total++;
            if (lb && $countones(~xp) > 1) begin
                bad++;
                $display("FAIL R8: got xp=%b expected at most one zero", xp);
            end
        end

        // R1: asynchronous reset during an active session
        apply("R3", 1'b1, 3'd4);
        #(CLK_PERIOD / 4);
        rst_n = 1'b0;
        #1;
        check("R1", {xp, lb}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        apply("R3", 1'b1, 3'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule